// File: doc/BRIEF.md
# SPI serial EEPROM byte sequencer

This block lets a host read or write single bytes in a small serial EEPROM over SPI mode 0. The host sets an address and, for a write, a data byte, then pulses a request. The block drives the chip-select line itself. That lets it shape the frames the memory expects, rather than letting select toggle after every byte.

A write takes two frames. The first carries the write-enable opcode on its own. The second carries the write opcode, the address and the data byte without a break in select. The block then holds off completion until the memory's internal write time has passed. A read is one frame: opcode, address, then a dummy byte whose clocks shift the stored value back in. The block ignores whatever the slave returns while it is sending opcode, address or write data. Completion is signalled by a one-cycle pulse, and the read value stays on a held output.

Top module: `spi_eeprom_seq`

## Requirements
- R1: SPI mode 0. The serial clock is low whenever select is high. Each clock high and low phase lasts HALF_CLKS system clocks. mosi changes only while the serial clock is low and goes MSB first. miso is sampled as the serial clock rises.
- R2: A write (rw_i = 0) first sends a frame holding only the byte 0x06 (8 serial clocks), then raises select.
- R3: The second frame of a write holds exactly the three bytes 0x02, address, data, with select low across all 24 serial clocks.
- R4: After select rises at the end of the write-data frame, done_o is held off and busy_o stays high for at least WR_CYCLE_CLKS system clocks.
- R5: A read (rw_i = 1) sends one frame holding exactly 0x03, address, 0x00. rdata_o takes the byte shifted in during the third byte and holds it until the next read completes.
- R6: Bytes shifted in during opcode, address or write-data bytes are discarded. A write never changes rdata_o.
- R7: Select stays high for at least CS_GAP_CLKS system clocks between any two frames.
- R8: A start_i sampled while busy_o is low begins an operation, and busy_o is high in the next cycle. done_o pulses for exactly one cycle per operation, and busy_o is low in that cycle.
- R9: A start_i seen while busy_o is high is ignored: no extra frame, and the running operation keeps its own address and data.
- R10: Out of reset, select is high, the serial clock is low, and busy_o, done_o and rdata_o are 0. Select stays high whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request, sampled while idle |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 8 | EEPROM byte address |
| wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| sclk_o | output | 1 | SPI serial clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | Serial data to the EEPROM |
| miso_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench runs every address through a write and a readback. The data pattern is a bijection, so both 0x00 and 0xFF are written and read back. A behavioural slave in the bench latches data only from a correctly framed enable-then-write pair, so merging the enable opcode into the write frame, or raising select between bytes, shows up as stale readback data.

While the slave is not driving, it returns 0xFF. Letting any but the dummy byte reach rdata_o therefore gives a visible wrong value, and a write that disturbs rdata_o is caught directly. Separate checks cover a shortened write-cycle wait, a short select gap, a clock phase of the wrong length, and a request sneaking in mid-operation, which would add a frame or corrupt the in-flight address.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] DUMMY    = 8'h00;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP, S_WCYC} state_e;
  typedef enum logic [1:0] {F_WREN, F_WRITE, F_READ} frame_e;
endpackage

// File: rtl/spi_eeprom_shifter.sv
module spi_eeprom_shifter #(
  parameter int HALF_CLKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic          active_q, sclk_q, done_q;
  logic [CW-1:0] half_cnt_q;
  logic [2:0]    bit_cnt_q;
  logic [7:0]    sh_q, rx_q;
  logic          half_last;

  assign half_last = (half_cnt_q == CW'(HALF_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      sclk_q     <= 1'b0;
      done_q     <= 1'b0;
      half_cnt_q <= '0;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      rx_q       <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q   <= 1'b1;
        sh_q       <= tx_i;
        half_cnt_q <= '0;
        bit_cnt_q  <= '0;
        sclk_q     <= 1'b0;
      end else if (active_q) begin
        if (half_last) begin
          half_cnt_q <= '0;
          if (!sclk_q) begin
            // rising edge: capture slave bit
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            // falling edge: advance to next bit
            sclk_q <= 1'b0;
            if (bit_cnt_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_cnt_q <= bit_cnt_q + 3'd1;
              sh_q      <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          half_cnt_q <= half_cnt_q + CW'(1);
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_eeprom_timer.sv
module spi_eeprom_timer #(
  parameter int LOAD_VAL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int W = (LOAD_VAL > 0) ? $clog2(LOAD_VAL + 1) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= W'(LOAD_VAL);
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
  import spi_eeprom_pkg::*;
#(
  parameter int HALF_CLKS     = 4,
  parameter int CS_GAP_CLKS   = 8,
  parameter int WR_CYCLE_CLKS = 250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rw_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  state_e     state_q;
  frame_e     frame_q;
  logic [1:0] idx_q;
  logic       go_q, cs_n_q, done_q;
  logic [7:0] addr_q, wdata_q, rdata_q;
  logic [7:0] tx_byte, rx_byte;
  logic       byte_done, last_byte, frame_end;
  logic       gap_load, gap_expired, wc_load, wc_expired;

  always_comb begin
    tx_byte = DUMMY;
    unique case (frame_q)
      F_WREN:  tx_byte = OP_WREN;
      F_WRITE: tx_byte = (idx_q == 2'd0) ? OP_WRITE :
                         (idx_q == 2'd1) ? addr_q : wdata_q;
      F_READ:  tx_byte = (idx_q == 2'd0) ? OP_READ :
                         (idx_q == 2'd1) ? addr_q : DUMMY;
      default: tx_byte = DUMMY;
    endcase
  end

  assign last_byte = (frame_q == F_WREN) || (idx_q == 2'd2);
  assign frame_end = (state_q == S_XFER) && byte_done && last_byte;
  assign gap_load  = frame_end && (frame_q != F_WRITE);
  assign wc_load   = frame_end && (frame_q == F_WRITE);

  spi_eeprom_shifter #(.HALF_CLKS(HALF_CLKS)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_q),
    .tx_i   (tx_byte),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .rx_o   (rx_byte),
    .done_o (byte_done)
  );

  spi_eeprom_timer #(.LOAD_VAL(CS_GAP_CLKS)) i_gap_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gap_load),
    .expired_o (gap_expired)
  );

  spi_eeprom_timer #(.LOAD_VAL(WR_CYCLE_CLKS)) i_wcyc_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wc_load),
    .expired_o (wc_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      frame_q <= F_WREN;
      idx_q   <= '0;
      go_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          frame_q <= rw_i ? F_READ : F_WREN;
          idx_q   <= '0;
          cs_n_q  <= 1'b0;
          go_q    <= 1'b1;
          state_q <= S_XFER;
        end
        S_XFER: if (byte_done) begin
          if (last_byte) begin
            cs_n_q <= 1'b1;
            if (frame_q == F_READ) rdata_q <= rx_byte;
            state_q <= (frame_q == F_WRITE) ? S_WCYC : S_GAP;
          end else begin
            idx_q <= idx_q + 2'd1;
            go_q  <= 1'b1;
          end
        end
        S_GAP: if (gap_expired) begin
          if (frame_q == F_WREN) begin
            frame_q <= F_WRITE;
            idx_q   <= '0;
            cs_n_q  <= 1'b0;
            go_q    <= 1'b1;
            state_q <= S_XFER;
          end else begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_WCYC: if (wc_expired) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign cs_no   = cs_n_q;
endmodule

// File: rtl/spi_eeprom_seq_chk.sv
module spi_eeprom_seq_chk #(
  parameter int CS_GAP_CLKS = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o
);
  int unsigned hi_cnt;

  // consecutive cycles with select high; reset counts as a long idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_cnt <= 32'hFFFF_FFFF;
    else if (!cs_no)              hi_cnt <= 0;
    else if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
  end

  a_r1_sclk_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r1_mosi_stable_sclk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o) |-> $stable(mosi_o));

  a_r7_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= CS_GAP_CLKS));

  a_r8_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r10_idle_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
endmodule

bind spi_eeprom_seq spi_eeprom_seq_chk #(.CS_GAP_CLKS(CS_GAP_CLKS)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sclk_o  (sclk_o),
  .cs_no   (cs_no),
  .mosi_o  (mosi_o)
);

// File: tb/test_spi_eeprom_seq.sv
module test_spi_eeprom_seq;
  localparam int HALF = 2;
  localparam int GAP  = 6;
  localparam int WCYC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rw = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic busy, done, sclk, cs_n, mosi;
  logic [7:0] rdata;
  logic miso = 1'b1;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_eeprom_seq #(.HALF_CLKS(HALF), .CS_GAP_CLKS(GAP), .WR_CYCLE_CLKS(WCYC)) i_spi_eeprom_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rw_i(rw), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM slave ----------------
  logic [7:0] mem [256];
  logic [7:0] sh_in;
  int bitcnt = 0;
  logic wel = 1'b0;
  int fr_cnt = 0;
  int fr_bits [8];
  logic [7:0] fr_b [8][4];

  always @(negedge cs_n) begin
    bitcnt = 0;
    sh_in  = 8'h00;
  end

  always @(posedge sclk) if (!cs_n) begin
    sh_in  = {sh_in[6:0], mosi};
    bitcnt = bitcnt + 1;
    if (bitcnt % 8 == 0 && bitcnt <= 32 && fr_cnt < 8) fr_b[fr_cnt][bitcnt/8-1] = sh_in;
  end

  always @(negedge sclk) if (!cs_n) begin
    if (bitcnt >= 16 && bitcnt < 24 && fr_cnt < 8 && fr_b[fr_cnt][0] == 8'h03)
      miso = mem[fr_b[fr_cnt][1]][23-bitcnt];
    else
      miso = 1'b1;
  end

  always @(posedge cs_n) if (fr_cnt < 8) begin
    fr_bits[fr_cnt] = bitcnt;
    if (bitcnt == 8 && fr_b[fr_cnt][0] == 8'h06) wel = 1'b1;
    if (bitcnt == 24 && fr_b[fr_cnt][0] == 8'h02 && wel) begin
      mem[fr_b[fr_cnt][1]] = fr_b[fr_cnt][2];
      wel = 1'b0;
    end
    fr_cnt = fr_cnt + 1;
    miso = 1'b1;
  end

  // ---------------- timing monitors ----------------
  int hi_run = 0, cs_hi_run = 1000, since_rise = 0;
  logic cs_prev = 1'b1, done_prev = 1'b0;
  bit last_was_write = 0;

  always @(negedge clk) if (rst_n) begin
    if (sclk) hi_run++;
    else if (hi_run != 0) begin
      chk(hi_run == HALF, "R1 sclk high phase", hi_run, HALF);
      hi_run = 0;
    end
    if (cs_n) cs_hi_run++;
    else if (cs_prev) begin
      chk(cs_hi_run >= GAP, "R7 cs gap", cs_hi_run, GAP);
      cs_hi_run = 0;
    end
    if (cs_n && !cs_prev) since_rise = 0; else since_rise++;
    if (done) begin
      chk(!busy, "R8 busy low with done", busy, 0);
      chk(!done_prev, "R8 done one cycle", done_prev, 0);
      if (last_was_write) chk(since_rise >= WCYC, "R4 write cycle wait", since_rise, WCYC);
    end
    cs_prev   = cs_n;
    done_prev = done;
  end

  // ---------------- operations ----------------
  task automatic do_op(input bit is_rd, input logic [7:0] a, input logic [7:0] d);
    fr_cnt = 0;
    last_was_write = !is_rd;
    @(negedge clk);
    start = 1'b1; rw = is_rd; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8 busy after start", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 91) & 8'hFF);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0, "R10 reset select/clock", {cs_n, sclk}, 2'b10);
    chk(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {busy, done}, 0);
    chk(rdata == 8'h00, "R10 reset rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && !busy, "R10 idle deselected", cs_n, 1);

    // write sweep: R2, R3
    for (int a = 0; a < 256; a++) begin
      do_op(1'b0, 8'(a), pat(a));
      chk(fr_cnt == 2, "R2 write frame count", fr_cnt, 2);
      chk(fr_bits[0] == 8 && fr_b[0][0] == 8'h06, "R2 enable frame", {fr_bits[0][7:0], fr_b[0][0]}, 16'h0806);
      chk(fr_bits[1] == 24, "R3 write frame length", fr_bits[1], 24);
      chk({fr_b[1][0], fr_b[1][1], fr_b[1][2]} == {8'h02, 8'(a), pat(a)}, "R3 write frame bytes",
          {fr_b[1][0], fr_b[1][1], fr_b[1][2]}, {8'h02, 8'(a), pat(a)});
      chk(rdata == 8'h00, "R6 rdata untouched by write", rdata, 0);
    end

    // read sweep: R5
    for (int a = 0; a < 256; a++) begin
      do_op(1'b1, 8'(a), 8'hA5);
      chk(fr_cnt == 1 && fr_bits[0] == 24, "R5 read frame length", fr_bits[0], 24);
      chk({fr_b[0][0], fr_b[0][1], fr_b[0][2]} == {8'h03, 8'(a), 8'h00}, "R5 read frame bytes",
          {fr_b[0][0], fr_b[0][1], fr_b[0][2]}, {8'h03, 8'(a), 8'h00});
      chk(rdata == pat(a), "R5 read data", rdata, pat(a));
    end

    // R6: a write after a read leaves rdata holding the read value
    do_op(1'b1, 8'h10, 8'h00);
    chk(rdata == pat(16), "R5 read before R6", rdata, pat(16));
    do_op(1'b0, 8'h20, 8'h3C);
    chk(rdata == pat(16), "R6 write keeps rdata", rdata, pat(16));
    repeat (5) @(negedge clk);
    chk(rdata == pat(16), "R5 rdata held", rdata, pat(16));

    // R9: request while busy is ignored
    fr_cnt = 0;
    last_was_write = 1;
    @(negedge clk);
    start = 1'b1; rw = 1'b0; addr = 8'h44; wdata = 8'h9E;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1; rw = 1'b1; addr = 8'h55; wdata = 8'h00;
    @(negedge clk);
    start = 1'b0; addr = 8'h00;
    while (!done) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(fr_cnt == 2, "R9 no extra frame", fr_cnt, 2);
    chk(!busy, "R9 idle after ignored request", busy, 0);
    chk({fr_b[1][1], fr_b[1][2]} == 16'h449E, "R9 in-flight address/data kept",
        {fr_b[1][1], fr_b[1][2]}, 16'h449E);
    do_op(1'b1, 8'h44, 8'h00);
    chk(rdata == 8'h9E, "R9 written value read back", rdata, 8'h9E);
    do_op(1'b1, 8'h55, 8'h00);
    chk(rdata == pat(85), "R9 other address untouched", rdata, pat(85));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule